// File: doc/BRIEF.md
# Loop Current Level Quantizer

This block turns a stream of DC loop current measurements, taken while the line is off-hook, into a coarse 4-bit level code. Each measurement is an unsigned count of 0.5 mA units and comes with a one-cycle valid strobe. Software and line-supervision logic use the code as a relative gauge of loop health, not as an exact reading.

The code boundaries are uniform 6 mA steps, with a separate top step at 140 mA. Each boundary has 2 mA of hysteresis, so a current that sits near a boundary does not make the code toggle. Code 0 raises an undercurrent flag, which means the line should be released.

The block also watches for a parallel handset going off-hook. That event roughly halves the loop current. When a code that has been steady for a while falls to half or less of its value, the block emits a single-cycle extension-pickup pulse.

Top module: `loop_level_q`

## Requirements
- R1: After reset, and until the first valid sample has been taken, level_code is 0, under_flag is 1 and pickup_pulse is 0.
- R2: Boundary k (k = 0..14) lies at 12·(k+1) units for k < 14 and at 280 units for k = 14. The code moves above boundary k only when cur_level > boundary + 4 units.
- R3: The code drops below boundary k only when cur_level < boundary − 4 units.
- R4: A sample that falls inside a boundary's ±4-unit window, or between windows, leaves the code at its current value, provided the code already lies on the matching side.
- R5: A single valid sample may move the code across several boundaries at once, straight to the level that R2 and R3 select.
- R6: The code saturates: it never goes below 0 or above 15. Any current above 284 units gives 15.
- R7: under_flag is 1 exactly when level_code is 0.
- R8: Cycles with cur_valid low change neither the code nor the pickup detector, whatever cur_level carries.
- R9: pickup_pulse goes high for one cycle when all of the following hold: a valid sample lowers the code from old to new; old ≥ 4; 2·new ≤ old; and old was the result of at least 8 consecutive valid samples. The sample that set old counts toward the 8. After reset, the count starts with the first sample.
- R10: No pulse occurs when the previous code was held for fewer than 8 samples, when the previous code was below 4, or when the new code is more than half the previous one.
- R11: level_code and pickup_pulse change on the first clock edge after the valid sample, that is, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_valid | input | 1 | Measurement strobe |
| cur_level | input | 10 | Loop current in 0.5 mA units |
| level_code | output | 4 | Quantized loop current level |
| under_flag | output | 1 | High while the code is 0 |
| pickup_pulse | output | 1 | One-cycle extension-pickup indication |

## Verification
A slow ramp from 0 to 300 units and back visits every boundary one unit at a time. This separates the rising thresholds from the falling ones and shows the hold band of each boundary.

Large single-sample jumps show that the code moves across several boundaries in one step rather than one code per sample.

Scripted hold-and-drop sequences exercise the pickup rule. They vary the hold length (7 against 8 samples), the starting code (3 against 4 and above) and the drop ratio (exactly half against just over half).

A long run of random currents, with idle cycles that carry junk on cur_level, is compared against a one-step-at-a-time reference model. This shows that the idle cycles are ignored and that no corner of the rules was missed.

// File: rtl/loop_level_q.sv
module loop_level_q #(
  parameter int IW       = 10,
  parameter int STEP     = 12,
  parameter int HYS      = 4,
  parameter int TOP      = 280,
  parameter int HOLD_N   = 8,
  parameter int PICK_MIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cur_valid,
  input  logic [IW-1:0] cur_level,
  output logic [3:0]    level_code,
  output logic          under_flag,
  output logic          pickup_pulse
);
  localparam int NB   = 15;
  localparam int CNTW = $clog2(HOLD_N + 1);

  logic [3:0]      code_q, up_c, dn_c, code_d;
  logic [CNTW-1:0] run_q;
  logic            pulse_q, changed, pick;

  function automatic int edge_at(int k);
    return (k == NB - 1) ? TOP : STEP * (k + 1);
  endfunction

  always_comb begin
    up_c = '0;
    dn_c = '0;
    for (int k = 0; k < NB; k++) begin
      if (int'(cur_level) > edge_at(k) + HYS) up_c = up_c + 4'd1;
      if (int'(cur_level) + HYS >= edge_at(k)) dn_c = dn_c + 4'd1;
    end
  end

  assign code_d  = (up_c > code_q) ? up_c : (dn_c < code_q) ? dn_c : code_q;
  assign changed = code_d != code_q;
  assign pick    = changed && (code_q >= 4'(PICK_MIN)) &&
                   ({code_d, 1'b0} <= {1'b0, code_q}) && (run_q >= CNTW'(HOLD_N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      run_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= cur_valid && pick;
      if (cur_valid) begin
        code_q <= code_d;
        if (changed)                     run_q <= CNTW'(1);
        else if (run_q < CNTW'(HOLD_N))  run_q <= run_q + CNTW'(1);
      end
    end
  end

  assign level_code   = code_q;
  assign under_flag   = (code_q == 4'd0);
  assign pickup_pulse = pulse_q;
endmodule

module loop_level_q_chk #(
  parameter int IW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cur_valid,
  input logic [IW-1:0] cur_level,
  input logic [3:0]    level_code,
  input logic          under_flag,
  input logic          pickup_pulse
);
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rst_n) && !$past(cur_valid)) |-> $stable(level_code));

  a_r2_rise_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && level_code > $past(level_code)) |-> $past(cur_level) > 16);

  a_r3_fall_max: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && level_code < $past(level_code)) |-> $past(cur_level) < 276);

  a_r9_pulse_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pickup_pulse |-> ($past(level_code) >= 4 && {level_code, 1'b0} <= {1'b0, $past(level_code)}));

  a_r11_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    pickup_pulse |=> !pickup_pulse);

  a_r7_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(under_flag) |-> $past(cur_valid));
endmodule

bind loop_level_q loop_level_q_chk #(.IW(IW)) u_chk (.*);

// File: tb/sim_loop_level_q.sv
`timescale 1ns/1ps
module sim_loop_level_q;
  logic       clk = 0, rst_n = 0, cur_valid = 0;
  logic [9:0] cur_level = '0;
  logic [3:0] level_code;
  logic       under_flag, pickup_pulse;
  int checks = 0, fails = 0;
  int mcode = 0, mrun = 0, mpulse = 0;

  always #2 clk = ~clk;

  loop_level_q u0 (.clk, .rst_n, .cur_valid, .cur_level, .level_code, .under_flag, .pickup_pulse);

  function automatic int bnd(int k);
    return (k == 14) ? 280 : 12 * (k + 1);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic sample(int v, string tag);
    int c, old;
    @(negedge clk);
    cur_valid = 1; cur_level = 10'(v);
    old = mcode; c = mcode;
    while (c < 15 && v > bnd(c) + 4) c++;
    while (c > 0 && v < bnd(c - 1) - 4) c--;
    mpulse = (c < old && old >= 4 && 2 * c <= old && mrun >= 8) ? 1 : 0;
    if (c != old) mrun = 1; else if (mrun < 8) mrun++;
    mcode = c;
    @(negedge clk);
    cur_valid = 0; cur_level = 10'($urandom_range(0, 1023));
    check({tag, " code"}, level_code, mcode);
    check("R7 flag", under_flag, mcode == 0);
    check({tag, " pulse"}, pickup_pulse, mpulse);
  endtask

  task automatic hold(int v, int n, string tag);
    for (int i = 0; i < n; i++) sample(v, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 code", level_code, 0);
    check("R1 flag", under_flag, 1);
    check("R1 pulse", pickup_pulse, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check("R8 idle code", level_code, 0);
    for (int v = 0; v <= 300; v++) sample(v, "R2");
    check("R6 top", level_code, 15);
    for (int v = 300; v >= 0; v--) sample(v, "R3");
    check("R6 bottom", level_code, 0);
    sample(80, "R4"); sample(76, "R4"); sample(68, "R4"); sample(67, "R4");
    sample(0, "R5"); sample(200, "R5"); sample(1023, "R6"); sample(20, "R5");
    hold(132, 8, "R9"); sample(60, "R9");
    check("R9 pulse seen", pickup_pulse, 1);
    @(negedge clk);
    check("R11 pulse width", pickup_pulse, 0);
    hold(132, 7, "R10"); sample(60, "R10");
    check("R10 short hold", pickup_pulse, 0);
    hold(84, 8, "R9"); sample(40, "R9");
    check("R9 exact half", pickup_pulse, 1);
    hold(40, 8, "R10"); sample(16, "R10");
    check("R10 low start", pickup_pulse, 0);
    hold(132, 8, "R10"); sample(80, "R10");
    check("R10 shallow drop", pickup_pulse, 0);
    for (int i = 0; i < 4000; i++) begin
      int v = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 1023) : $urandom_range(0, 300);
      hold(v, $urandom_range(1, 10), "R8");
    end
    finish_run();
  end
endmodule